// File: doc/BRIEF.md
# Device Interrupt Status Aggregator

This block gathers the interrupt events of a USB device controller into one 32-bit status word and drives a single active-high level interrupt to the host processor. Single-cycle event pulses from the endpoint buffers, the setup-packet detector and the bus-state monitor each set their own sticky bit. A separate reason register records which DMA source raised an interrupt, and one summary bit in the status word follows it. The processor reads both registers through a plain register port and clears bits by writing ones to them.

Every status bit stays set until software clears it, and a pulse that arrives in the same cycle as a clear always wins. A bus reset empties the status word, leaving only its own bit set. The DMA summary bit cannot be cleared while any reason bit is still pending. Software clears the source in the reason register first, then writes one to the summary bit. The register port is plain control and status, with no handshake. Reads are combinational and have no side effects.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word, the reason register and `irq` are all 0.
- R2: A pulse on `ep_tx_evt[n]` sets status bit 8+n and a pulse on `ep_rx_evt[n]` sets status bit 16+n (n = 0..7) at the next clock edge. Bits 7 and 31:24 always read 0.
- R3: At the next edge, `setup_evt` sets status bit 5, `resume_evt` bit 4, `suspend_evt` bit 3, `psof_evt` bit 2 and `sof_evt` bit 1.
- R4: A write to address 0 clears every status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set. This holds in both registers.
- R6: A `busrst_evt` pulse makes the status word exactly 0x0000_0001 at the next edge, whatever else was pending.
- R7: `irq` is a registered output that is 1 exactly when the status word is non-zero.
- R8: A pulse on `dma_src_evt[k]` sets bit k of the reason register at address 1. Writing 1 to a reason bit clears it. Bits above the source width read 0.
- R9: Status bit 6 becomes 1 at the edge after any reason bit is held set, which is two edges after the source pulse.
- R10: While any reason bit is set, a write of 1 to status bit 6 leaves it set. Once the reason register is empty, such a write clears it.
- R11: Reads change no state. Any address other than 0 and 1 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address: 0 status, 1 DMA reason |
| reg_wdata | input | 32 | Write data (ones clear) |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| ep_tx_evt | input | 8 | Per-endpoint transmit-complete pulses |
| ep_rx_evt | input | 8 | Per-endpoint receive pulses |
| setup_evt | input | 1 | Setup packet received on endpoint 0 |
| resume_evt | input | 1 | Bus resume detected |
| suspend_evt | input | 1 | Bus suspend detected |
| psof_evt | input | 1 | Pseudo start-of-frame |
| sof_evt | input | 1 | Start-of-frame |
| busrst_evt | input | 1 | Bus reset detected |
| dma_src_evt | input | DMA_SRC_W | DMA interrupt source pulses |
| irq | output | 1 | Level interrupt, active high |

## Verification
Each event pulse, clearing write and the `irq` level takes effect at the first clock edge after it is driven. A DMA source pulse reaches the summary bit one edge later than it reaches the reason register. The bench drives every input at a falling edge and holds it across exactly one rising edge. Each read is then scored at the following falling edge, before the next rising edge can change the state. The DMA sequence deliberately reads the status word between the two edges to confirm the one-cycle lag.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_EP      = 8;
  localparam int BIT_BUSRST  = 0;
  localparam int BIT_SOF     = 1;
  localparam int BIT_PSOF    = 2;
  localparam int BIT_SUSPEND = 3;
  localparam int BIT_RESUME  = 4;
  localparam int BIT_SETUP   = 5;
  localparam int BIT_DMA     = 6;
  localparam int EP_TX_BASE  = 8;
  localparam int EP_RX_BASE  = EP_TX_BASE + NUM_EP;
  localparam int STATUS_ADDR = 0;
  localparam int REASON_ADDR = 1;

  function automatic logic [DATA_W-1:0] status_impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = BIT_BUSRST; b <= BIT_DMA; b++) m[b] = 1'b1;
    for (int e = 0; e < NUM_EP; e++) begin
      m[EP_TX_BASE + e] = 1'b1;
      m[EP_RX_BASE + e] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] STATUS_IMPL = status_impl_mask();
  localparam logic [DATA_W-1:0] STATUS_KEEP = DATA_W'(1) << BIT_BUSRST;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL  = '1,
  parameter logic [WIDTH-1:0] KEEP  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_nxt
);
  // set dominates clear; flush keeps only the KEEP positions of set_vec
  always_comb begin
    if (flush) q_nxt = set_vec & KEEP;
    else       q_nxt = ((q & ~clr_vec) | set_vec) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/irq_evt_pack.sv
module irq_evt_pack
  import irq_agg_pkg::*;
(
  input  logic [NUM_EP-1:0] ep_tx_evt,
  input  logic [NUM_EP-1:0] ep_rx_evt,
  input  logic              setup_evt,
  input  logic              resume_evt,
  input  logic              suspend_evt,
  input  logic              psof_evt,
  input  logic              sof_evt,
  input  logic              busrst_evt,
  input  logic              dma_pending,
  output logic [DATA_W-1:0] set_vec
);
  logic [DATA_W-1:0] ep_part;
  logic [DATA_W-1:0] bus_part;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign ep_part[EP_TX_BASE + e] = ep_tx_evt[e];
    assign ep_part[EP_RX_BASE + e] = ep_rx_evt[e];
  end
  if (EP_RX_BASE + NUM_EP < DATA_W) begin : g_hi
    assign ep_part[DATA_W-1:EP_RX_BASE+NUM_EP] = '0;
  end
  assign ep_part[EP_TX_BASE-1:0] = '0;

  always_comb begin
    bus_part              = '0;
    bus_part[BIT_BUSRST]  = busrst_evt;
    bus_part[BIT_SOF]     = sof_evt;
    bus_part[BIT_PSOF]    = psof_evt;
    bus_part[BIT_SUSPEND] = suspend_evt;
    bus_part[BIT_RESUME]  = resume_evt;
    bus_part[BIT_SETUP]   = setup_evt;
    bus_part[BIT_DMA]     = dma_pending;
  end

  assign set_vec = ep_part | bus_part;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DMA_SRC_W = 8
) (
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [DATA_W-1:0]    status_q,
  input  logic [DMA_SRC_W-1:0] reason_q,
  output logic [DATA_W-1:0]    clr_status,
  output logic [DMA_SRC_W-1:0] clr_reason,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_REASON = ADDR_W'(REASON_ADDR);

  logic wr_hit, rd_hit;
  assign wr_hit = reg_sel &  reg_wr;
  assign rd_hit = reg_sel & ~reg_wr;

  assign clr_status = (wr_hit && reg_addr == A_STATUS) ? reg_wdata : '0;
  assign clr_reason = (wr_hit && reg_addr == A_REASON) ? reg_wdata[DMA_SRC_W-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    if (rd_hit) begin
      if (reg_addr == A_STATUS)      reg_rdata = status_q;
      else if (reg_addr == A_REASON) reg_rdata = DATA_W'(reason_q);
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DMA_SRC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [7:0]           ep_tx_evt,
  input  logic [7:0]           ep_rx_evt,
  input  logic                 setup_evt,
  input  logic                 resume_evt,
  input  logic                 suspend_evt,
  input  logic                 psof_evt,
  input  logic                 sof_evt,
  input  logic                 busrst_evt,
  input  logic [DMA_SRC_W-1:0] dma_src_evt,
  output logic                 irq
);
  logic [DATA_W-1:0]    status_q, status_nxt, status_set, clr_status;
  logic [DMA_SRC_W-1:0] reason_q, reason_nxt, clr_reason;
  logic                 irq_q;

  irq_evt_pack u_pack (
    .ep_tx_evt   (ep_tx_evt),
    .ep_rx_evt   (ep_rx_evt),
    .setup_evt   (setup_evt),
    .resume_evt  (resume_evt),
    .suspend_evt (suspend_evt),
    .psof_evt    (psof_evt),
    .sof_evt     (sof_evt),
    .busrst_evt  (busrst_evt),
    .dma_pending (|reason_q),
    .set_vec     (status_set)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .DMA_SRC_W(DMA_SRC_W)) u_dec (
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .status_q   (status_q),
    .reason_q   (reason_q),
    .clr_status (clr_status),
    .clr_reason (clr_reason),
    .reg_rdata  (reg_rdata)
  );

  irq_w1c_bank #(.WIDTH(DATA_W), .IMPL(STATUS_IMPL), .KEEP(STATUS_KEEP)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (busrst_evt),
    .set_vec (status_set),
    .clr_vec (clr_status),
    .q       (status_q),
    .q_nxt   (status_nxt)
  );

  irq_w1c_bank #(.WIDTH(DMA_SRC_W)) u_reason (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (1'b0),
    .set_vec (dma_src_evt),
    .clr_vec (clr_reason),
    .q       (reason_q),
    .q_nxt   (reason_nxt)
  );

  // interrupt flop tracks the next status value so it lines up with status_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |status_nxt;
  end
  assign irq = irq_q;

  logic unused_ok;
  assign unused_ok = ^reason_nxt;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DMA_SRC_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_sel,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [7:0]           ep_tx_evt,
  input logic [7:0]           ep_rx_evt,
  input logic                 setup_evt,
  input logic                 busrst_evt,
  input logic                 irq,
  input logic [31:0]          status_q,
  input logic [DMA_SRC_W-1:0] reason_q
);
  // R7: interrupt level mirrors a non-zero status word
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|status_q));

  // R5: a set pulse always lands, even against a clear write
  assert_setup_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_evt && !busrst_evt) |=> status_q[BIT_SETUP]);

  // R6: bus reset leaves only its own bit
  assert_busrst_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busrst_evt |=> (status_q == 32'h1));

  // R9: a pending reason forces the summary bit on
  assert_dma_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|reason_q) && !busrst_evt) |=> status_q[BIT_DMA]);

  // R4: a clearing write with no competing event clears the bit
  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_addr == ADDR_W'(STATUS_ADDR) && reg_wdata[EP_TX_BASE]
     && !ep_tx_evt[0]) |=> !status_q[EP_TX_BASE]);

  // R2: an endpoint bit only rises after its own pulse
  assert_rx_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[EP_RX_BASE]) |-> $past(ep_rx_evt[0]));

  // R2: reserved positions read zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == ADDR_W'(STATUS_ADDR))
      |-> ((reg_rdata & ~STATUS_IMPL) == 32'h0));
endmodule

bind irq_status_agg irq_agg_chk #(.ADDR_W(ADDR_W), .DMA_SRC_W(DMA_SRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ep_tx_evt  (ep_tx_evt),
  .ep_rx_evt  (ep_rx_evt),
  .setup_evt  (setup_evt),
  .busrst_evt (busrst_evt),
  .irq        (irq),
  .status_q   (status_q),
  .reason_q   (reason_q)
);

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;
  localparam time CLK_PERIOD = 10;
  localparam int  AW = 4;
  localparam int  SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_sel = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [7:0]    ep_tx_evt = '0, ep_rx_evt = '0;
  logic          setup_evt = 0, resume_evt = 0, suspend_evt = 0;
  logic          psof_evt = 0, sof_evt = 0, busrst_evt = 0;
  logic [SW-1:0] dma_src_evt = '0;
  logic          irq;

  irq_status_agg #(.ADDR_W(AW), .DMA_SRC_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt), .setup_evt(setup_evt),
    .resume_evt(resume_evt), .suspend_evt(suspend_evt), .psof_evt(psof_evt),
    .sof_evt(sof_evt), .busrst_evt(busrst_evt), .dma_src_evt(dma_src_evt),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    logic        exp_irq;
    logic        chk_irq;
    string       tag;
  } item_t;

  item_t sb[$];
  event  mon_ev;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  // monitor: pops the expected item and scores the live outputs
  initial begin
    item_t it;
    forever begin
      @(mon_ev);
      it = sb.pop_front();
      n_vec++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
      end
      if (it.chk_irq) begin
        n_vec++;
        if (irq !== it.exp_irq) begin
          n_bad++;
          $display("FAIL %s irq=%b expected=%b", it.tag, irq, it.exp_irq);
        end
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1;
    it.exp = e; it.exp_irq = |e; it.chk_irq = (a == 0); it.tag = tag;
    sb.push_back(it);
    -> mon_ev;
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic clear_pulses();
    ep_tx_evt = '0; ep_rx_evt = '0; setup_evt = 0; resume_evt = 0;
    suspend_evt = 0; psof_evt = 0; sof_evt = 0; busrst_evt = 0; dma_src_evt = '0;
    reg_sel = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, 32'h0, "R1 status after reset");
    rd(1, 32'h0, "R1 reason after reset");

    ep_tx_evt[3] = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0000_0800, "R2 tx3 bit11 R7");

    ep_rx_evt[7] = 1; setup_evt = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0080_0820, "R2 rx7 bit23 R3 setup");

    wr(0, 32'h0000_0800);
    rd(0, 32'h0080_0020, "R4 clear tx3 keep others");

    resume_evt = 1; suspend_evt = 1; psof_evt = 1; sof_evt = 1;
    @(negedge clk); clear_pulses();
    rd(0, 32'h0080_003E, "R3 bus-state bits");

    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R4 clear all R7 irq low");

    // set and clear collide on tx0 (bit8)
    ep_tx_evt[0] = 1; reg_sel = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h100;
    @(negedge clk); clear_pulses();
    rd(0, 32'h0000_0100, "R5 set beats clear");
    wr(0, 32'h0000_0100);
    wr(0, 32'hFF00_0080);
    rd(0, 32'h0, "R2 reserved bits read zero");

    ep_rx_evt[2] = 1; @(negedge clk); clear_pulses();
    wr(2, 32'hFFFF_FFFF);
    rd(0, 32'h0004_0000, "R11 write to unmapped ignored");
    rd(0, 32'h0004_0000, "R11 repeat read no side effect");
    rd(2, 32'h0, "R11 unmapped reads zero");
    wr(0, 32'h0004_0000);

    ep_rx_evt[0] = 1; ep_tx_evt[7] = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0001_8000, "R2 rx0 tx7");
    busrst_evt = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0000_0001, "R6 bus reset flushes");
    wr(0, 32'h1);
    rd(0, 32'h0, "R4 bus reset bit cleared");

    dma_src_evt[2] = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0, "R9 summary lags one cycle");
    rd(1, 32'h0000_0004, "R8 reason bit2");
    rd(0, 32'h0000_0040, "R9 summary set");
    wr(0, 32'h40);
    rd(0, 32'h0000_0040, "R10 summary held by reason");
    wr(1, 32'h4);
    rd(1, 32'h0, "R8 reason cleared");
    wr(0, 32'h40);
    rd(0, 32'h0, "R10 summary cleared");

    dma_src_evt[5] = 1; reg_sel = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); clear_pulses();
    rd(1, 32'h0000_0020, "R8 reason set wins upper zero R5");
    rd(0, 32'h0000_0040, "R9 summary from reason5");
    busrst_evt = 1; @(negedge clk); clear_pulses();
    rd(0, 32'h0000_0001, "R6 flush drops summary");
    rd(0, 32'h0000_0041, "R10 summary returns after flush");
    wr(1, 32'h20);
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R1 idle after cleanup");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule